// File: doc/BRIEF.md
# Synchronous Reset Pulse-Width Filter

This block turns a raw power-on reset line into a clean reset that is synchronous to the local clock. The raw line is asynchronous to the clock and may carry runt pulses or noise. The block samples the line through a chain of synchronizing flip-flops. It asserts its output only after the synchronized line has been active on a configurable number of consecutive rising edges, so any pulse narrower than that window is rejected. Release needs no qualification. The output drops on the edge that first sees the synchronized line inactive, so every downstream state machine leaves reset in the same clock period.

Qualification uses a thermometer-coded register chain. While the input stays active, each edge adds exactly one set bit. The output is the last bit of that chain, taken straight from a register, so it can only change on a rising clock edge. Every flop in the block powers up cleared, because the block has no reset of its own.

Top module: `por_width_filter`

## Requirements
- R1: Before the first rising clock edge, and after any run of samples shorter than the qualification length, the output `rst_sync_o` is 0. Both `por_raw_i` and `rst_sync_o` are active high.
- R2: Let the first rising edge that samples `por_raw_i` high be edge e0. If the input stays high for QUAL_LEN consecutive sampling edges, `rst_sync_o` goes to 1 on edge e0 + SYNC_LEN + QUAL_LEN - 1.
- R3: A pulse that is high on fewer than QUAL_LEN consecutive rising edges never asserts `rst_sync_o`.
- R4: A pulse that is high on W ≥ QUAL_LEN consecutive rising edges holds `rst_sync_o` at 1 for exactly W - QUAL_LEN + 1 clock cycles.
- R5: Changes of `por_raw_i` that begin and end between two rising edges have no effect on `rst_sync_o`.
- R6: Let f be the first rising edge that samples `por_raw_i` low. `rst_sync_o` returns to 0 on edge f + SYNC_LEN - 1 + 1, with no qualification delay.
- R7: `rst_sync_o` is driven by a register. Its value is constant between rising edges.
- R8: The qualification chain is thermometer coded: its set bits are always contiguous from bit 0. On an edge that sets any bit, exactly one bit changes.
- R9: If `por_raw_i` is held high from time zero, `rst_sync_o` is 1 after rising edge SYNC_LEN + QUAL_LEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| por_raw_i | input | 1 | Raw reset request, asynchronous to the clock, active high |
| rst_sync_o | output | 1 | Filtered reset, synchronous to the clock, active high |

## Verification
The bench builds the block with SYNC_LEN = 2 and QUAL_LEN = 3. With these values, pulses of one clock up to two clocks beyond the qualification length form a short enumerable list. The bench applies every width in that list at four phase offsets inside the clock period, and checks both the rise edge and the number of high cycles against arithmetic on those two parameters. Sub-cycle glitches and a held-from-power-up input complete the sweep. A mid-cycle resample of the output checks that it only moves at edges.

// File: rtl/por_filt_pkg.sv
package por_filt_pkg;
   // Smallest legal chain lengths; fewer synchronizer flops cannot resolve
   // a metastable first stage, fewer qualification samples cannot filter.
   localparam int unsigned MIN_SYNC_LEN = 2;
   localparam int unsigned MIN_QUAL_LEN = 2;
endpackage

// File: rtl/por_sync_chain.sv
module por_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic d_i,
   output logic q_o
);
   import por_filt_pkg::*;

   if (STAGES < MIN_SYNC_LEN) begin : g_bad_stages
      $error("por_sync_chain: STAGES must be at least %0d", MIN_SYNC_LEN);
   end

   logic [STAGES-1:0] stage_q = '0;

   always_ff @(posedge clk_i) begin
      stage_q <= {stage_q[STAGES-2:0], d_i};
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/por_qual_chain.sv
module por_qual_chain #(
   parameter int unsigned QUAL_LEN = 3
) (
   input  logic clk_i,
   input  logic level_i,
   output logic qual_o
);
   import por_filt_pkg::*;

   if (QUAL_LEN < MIN_QUAL_LEN) begin : g_bad_qual
      $error("por_qual_chain: QUAL_LEN must be at least %0d", MIN_QUAL_LEN);
   end

   // Bit k set means level_i was high on the last k+1 edges.
   logic [QUAL_LEN-1:0] therm_q = '0;
   logic [QUAL_LEN-1:0] therm_d;

   always_comb begin
      therm_d[0] = level_i;
      for (int k = 1; k < QUAL_LEN; k++) begin
         therm_d[k] = therm_q[k-1] & level_i;
      end
   end

   always_ff @(posedge clk_i) begin
      therm_q <= therm_d;
   end

   assign qual_o = therm_q[QUAL_LEN-1];

   logic armed_q = 1'b0;
   always_ff @(posedge clk_i) armed_q <= 1'b1;

   // R8
   therm_shape_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      ((therm_q & (therm_q + 1'b1)) == '0));

   // R8
   one_step_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      (|(therm_q & ~$past(therm_q))) |-> ($countones(therm_q ^ $past(therm_q)) == 1));
endmodule

// File: rtl/por_width_filter.sv
module por_width_filter #(
   parameter int unsigned SYNC_LEN = 2,
   parameter int unsigned QUAL_LEN = 3
) (
   input  logic clk_i,
   input  logic por_raw_i,
   output logic rst_sync_o
);
   localparam int unsigned RUN_W = $clog2(QUAL_LEN + 1);

   logic level_sync;

   por_sync_chain #(.STAGES(SYNC_LEN)) u_sync (
      .clk_i (clk_i),
      .d_i   (por_raw_i),
      .q_o   (level_sync)
   );

   por_qual_chain #(.QUAL_LEN(QUAL_LEN)) u_qual (
      .clk_i   (clk_i),
      .level_i (level_sync),
      .qual_o  (rst_sync_o)
   );

   // Checker state: saturating count of consecutive high synchronized samples.
   logic             armed_q = 1'b0;
   logic [RUN_W-1:0] run_q   = '0;

   always_ff @(posedge clk_i) begin
      armed_q <= 1'b1;
      if (!level_sync)                      run_q <= '0;
      else if (run_q != RUN_W'(QUAL_LEN))   run_q <= run_q + 1'b1;
   end

   // R3
   qual_width_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      rst_sync_o |-> (run_q == RUN_W'(QUAL_LEN)));

   // R6
   release_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      (rst_sync_o && !level_sync) |=> !rst_sync_o);

   // R2
   rise_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
      $rose(rst_sync_o) |-> $past(level_sync));
endmodule

// File: tb/sim_por_width_filter.sv
module sim_por_width_filter;
   localparam int S = 2;
   localparam int N = 3;

   logic clk = 1'b0;
   logic raw = 1'b1;
   logic rst;

   int tests  = 0;
   int fails  = 0;
   int pcount = 0;
   int hi_cnt = 0;
   int first_hi = -1;
   int mid_err  = 0;

   always #10 clk = ~clk;

   por_width_filter #(.SYNC_LEN(S), .QUAL_LEN(N)) u0 (
      .clk_i      (clk),
      .por_raw_i  (raw),
      .rst_sync_o (rst)
   );

   always @(posedge clk) pcount <= pcount + 1;

   always @(negedge clk) begin
      if (rst === 1'b1) begin
         hi_cnt = hi_cnt + 1;
         if (first_hi < 0) first_hi = pcount;
      end
   end

   // R7: output sampled early and late in each cycle must agree
   always @(posedge clk) begin
      logic a;
      #2 a = rst;
      #16 if (rst !== a) mid_err = mid_err + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      tests = tests + 1;
      if (act != exp) begin
         fails = fails + 1;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse(input int w, input int off);
      int k;
      @(posedge clk);
      #(off);
      k = pcount;
      hi_cnt = 0;
      first_hi = -1;
      raw = 1'b1;
      repeat (w) @(posedge clk);
      #(off);
      raw = 1'b0;
      repeat (S + N + 4) @(posedge clk);
      #5;
      if (w < N) begin
         check("R3 no assert on short pulse", hi_cnt, 0);
      end else begin
         check("R4 high cycles", hi_cnt, w - N + 1);
         check("R2 rise edge", first_hi - k, S + N);
      end
   endtask

   initial begin
      #1;
      check("R1 initial low", int'(rst), 0);
      // R9: held high from power-up
      wait (pcount == S + N - 1);
      @(negedge clk);
      check("R9 low before qualifying edge", int'(rst), 0);
      @(negedge clk);
      check("R9 high after SYNC_LEN+QUAL_LEN edges", int'(rst), 1);
      // R6: release latency
      @(posedge clk);
      #7 raw = 1'b0;
      repeat (S) @(posedge clk);
      #5 check("R6 still high before release edge", int'(rst), 1);
      @(posedge clk);
      #5 check("R6 low on release edge", int'(rst), 0);
      repeat (6) @(posedge clk);
      // sweep widths and phases
      for (int w = 1; w <= N + 2; w++) begin
         for (int p = 0; p < 4; p++) begin
            pulse(w, 3 + 5 * p);
         end
      end
      // R5: sub-cycle glitches
      for (int g = 0; g < 4; g++) begin
         @(posedge clk);
         #(2 + g);
         hi_cnt = 0;
         raw = 1'b1;
         #(5 + g) raw = 1'b0;
         repeat (S + N + 3) @(posedge clk);
         #5 check("R5 glitch between edges ignored", hi_cnt, 0);
      end
      check("R7 no mid-cycle change", mid_err, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule